// File: doc/BRIEF.md
# Banked Interrupt Priority Register

This block collects six block-level interrupt requests from a serial controller: timer, transmit machine, receive machine, receive FIFO, transmit FIFO and modem. Each cycle it samples them into a raw status register, which always shows every pending request whatever the enables say. An enable register then picks which sources may reach the encoded interrupt register. That register reports the highest-priority enabled pending source as a 3-bit code and an active-low pending flag, and it drives the interrupt pin.

The encoded interrupt register shares its byte with a two-bit bank pointer, which the host can read and write. It is decoded at address 2 whatever the bank pointer holds, so the host can always get back to bank 0. Status and enable are reached only through bank 0. The other banks belong to neighbouring blocks, so addresses 0 and 1 read as zero and ignore writes there.

The host port is a plain synchronous register port with read and write strobes. It has no back-pressure: a write takes effect at the clock edge where it is strobed. Read data and its valid flag appear one cycle after the read strobe. A read strobed in the same cycle as a write returns the value from before the write.

Top module: `ipr_top`

## Requirements
- R1: Status bit i equals request input i sampled at the previous clock edge, independent of the enable register. Bit layout, used at both status and enable: bit 0 timer, bit 1 transmit machine, bit 2 receive machine, bit 3 receive FIFO, bit 4 transmit FIFO, bit 5 modem. The status register reads at address 0 in bank 0, with bits 7:6 as 0, and ignores writes.
- R2: The enable register is at address 1 in bank 0 and uses the bit layout of R1. A write there stores data bits 5:0, and a read returns them with bits 7:6 as 0. In banks 1 to 3, addresses 0 and 1 read 0 and writes there change nothing.
- R3: The interrupt code is bits 3:1 of the register at address 2. It names the highest-priority source among those both pending in status and enabled: 101 timer, 100 transmit machine, 011 receive machine, 010 receive FIFO, 001 transmit FIFO, 000 modem.
- R4: The pending flag is bit 0 at address 2 and is active low: 0 when any enabled source is pending. When none is, it reads 1 and the code reads 000.
- R5: `irq_o` is high exactly when the pending flag reads 0, in the same cycle, with no added register stage.
- R6: The code is re-evaluated every cycle. A higher-priority request raised while a lower one is reported replaces the code one cycle after it appears at the input.
- R7: A write to address 2 loads only the bank pointer from data bits 6:5. The code and pending flag ignore the written data.
- R8: Address 2 decodes in every bank. Bits 6:5 read back the bank pointer, and bits 7 and 4 read 0.
- R9: After reset the bank pointer is 0, all enables are 0, status is 0, `irq_o` is low and `rd_valid_o` is low.
- R10: A read strobe in one cycle gives `rd_valid_o` high and `rd_data_o` set to the addressed value in the next cycle. Without a strobe, `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Block-level interrupt requests, layout as in R1 |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The bench builds the block with its default parameters: eight-bit data, three-bit address, four banks, with status, enable and interrupt register at addresses 0, 1 and 2. These defaults put all four banks within reach, so the bench can check the bank-0-only decode of status and enable as well as the always-present interrupt register. Because the six source positions are fixed by the default width, random request and enable patterns cover every pairing of priorities, including codes that change while the host keeps the same bank.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  // number of block-level sources and width of the encoded code
  localparam int NSRC   = 6;
  localparam int CODE_W = 3;

  // source positions, highest priority first
  localparam int SRC_TIMER = 0;
  localparam int SRC_TXM   = 1;
  localparam int SRC_RXM   = 2;
  localparam int SRC_RXF   = 3;
  localparam int SRC_TXF   = 4;
  localparam int SRC_MODEM = 5;

  // interrupt register field positions
  localparam int PEND_BIT = 0;
  localparam int CODE_LSB = 1;
  localparam int BANK_LSB = 5;

  // code reported for the source at priority position idx
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    return CODE_W'(NSRC - 1 - idx);
  endfunction
endpackage

// File: rtl/ipr_src_regs.sv
module ipr_src_regs
  import ipr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] enable_o,
  output logic [NSRC-1:0] masked_o
);
  // raw status: a plain sample of the requests, never masked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable_o <= '0;
    else if (en_we_i) enable_o <= en_wdata_i;
  end

  // the mask reaches only the encoded path
  assign masked_o = status_o & enable_o;
endmodule

// File: rtl/ipr_prio_enc.sv
module ipr_prio_enc
  import ipr_pkg::*;
(
  input  logic [NSRC-1:0]   masked_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pend_n_o
);
  // blocked[i]: some higher-priority (lower index) source is pending
  logic [NSRC-1:0]   blocked;
  logic [NSRC-1:0]   grant;
  logic [CODE_W-1:0] code_term [NSRC];

  assign blocked[0] = 1'b0;
  for (genvar i = 1; i < NSRC; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | masked_i[i-1];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_grant
    assign grant[i]     = masked_i[i] & ~blocked[i];
    assign code_term[i] = grant[i] ? src_code(i) : '0;
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NSRC; i++) code_o = code_o | code_term[i];
  end

  assign pend_n_o = ~(|masked_i);
endmodule

// File: rtl/ipr_host_port.sv
module ipr_host_port
  import ipr_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int NBANK     = 4,
  parameter int ADDR_STAT = 0,
  parameter int ADDR_EN   = 1,
  parameter int ADDR_IRQ  = 2,
  localparam int BANK_W   = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [NSRC-1:0]   status_i,
  input  logic [NSRC-1:0]   enable_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pend_n_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              en_we_o,
  output logic [NSRC-1:0]   en_wdata_o
);
  logic              home_bank;
  logic              hit_stat, hit_en, hit_irq;
  logic [DATA_W-1:0] irq_word, rd_mux;
  logic              unused_wdata;

  assign home_bank = (bank_o == '0);
  assign hit_stat  = home_bank && (addr_i == ADDR_W'(ADDR_STAT));
  assign hit_en    = home_bank && (addr_i == ADDR_W'(ADDR_EN));
  assign hit_irq   = (addr_i == ADDR_W'(ADDR_IRQ));

  assign en_we_o    = wr_en_i && hit_en;
  assign en_wdata_o = wdata_i[NSRC-1:0];
  assign unused_wdata = ^wdata_i;

  // bank pointer: the only writable field of the interrupt register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bank_o <= '0;
    else if (wr_en_i && hit_irq) bank_o <= wdata_i[BANK_LSB +: BANK_W];
  end

  always_comb begin
    irq_word                           = '0;
    irq_word[PEND_BIT]                 = pend_n_i;
    irq_word[CODE_LSB +: CODE_W]       = code_i;
    irq_word[BANK_LSB +: BANK_W]       = bank_o;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_irq)       rd_mux = irq_word;
    else if (hit_stat) rd_mux[NSRC-1:0] = status_i;
    else if (hit_en)   rd_mux[NSRC-1:0] = enable_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ipr_top.sv
module ipr_top
  import ipr_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int NBANK     = 4,
  parameter int ADDR_STAT = 0,
  parameter int ADDR_EN   = 1,
  parameter int ADDR_IRQ  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              irq_o
);
  localparam int BANK_W = $clog2(NBANK);

  logic [NSRC-1:0]   status, enable, masked, en_wdata;
  logic              en_we, pend_n;
  logic [CODE_W-1:0] code;
  logic [BANK_W-1:0] bank;

  ipr_src_regs u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .en_we_i    (en_we),
    .en_wdata_i (en_wdata),
    .status_o   (status),
    .enable_o   (enable),
    .masked_o   (masked)
  );

  ipr_prio_enc u_enc (
    .masked_i (masked),
    .code_o   (code),
    .pend_n_o (pend_n)
  );

  ipr_host_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK),
    .ADDR_STAT(ADDR_STAT), .ADDR_EN(ADDR_EN), .ADDR_IRQ(ADDR_IRQ)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .status_i   (status),
    .enable_i   (enable),
    .code_i     (code),
    .pend_n_i   (pend_n),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .bank_o     (bank),
    .en_we_o    (en_we),
    .en_wdata_o (en_wdata)
  );

  // pin follows the pending flag with no register stage
  assign irq_o = ~pend_n;
endmodule

// File: rtl/ipr_chk.sv
module ipr_chk #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 2,
  parameter int ADDR_EN = 1,
  parameter int ADDR_IRQ = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic              irq_o,
  input logic [5:0]        status,
  input logic [5:0]        enable,
  input logic [BANK_W-1:0] bank
);
  // R1
  status_tracks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> status == $past(req_i));

  // R4
  no_source_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == 6'd0) |-> !irq_o);

  // R5
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status & enable) != 6'd0));

  // R7
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(ADDR_IRQ)) |=> bank == $past(wdata_i[5 +: BANK_W]));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(ADDR_IRQ)) |=> $stable(bank));

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(ADDR_EN) && bank == '0) |=> $stable(enable));

  // R10
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  // R10
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind ipr_top ipr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .ADDR_EN(ADDR_EN), .ADDR_IRQ(ADDR_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rd_valid_o(rd_valid_o), .irq_o(irq_o), .status(status),
  .enable(enable), .bank(bank)
);

// File: tb/ipr_top_test.sv
module ipr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req_i = '0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic [5:0] m_en   = '0;
  logic [1:0] m_bank = '0;

  always #5 clk = ~clk;

  ipr_top uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .irq_o(irq_o)
  );

  // encoding from the priority table of R3
  function automatic logic [2:0] want_code(input logic [5:0] m);
    if (m[0])      return 3'b101;
    else if (m[1]) return 3'b100;
    else if (m[2]) return 3'b011;
    else if (m[3]) return 3'b010;
    else if (m[4]) return 3'b001;
    else           return 3'b000;
  endfunction

  function automatic logic [7:0] want_irq_word(input logic [5:0] st,
                                               input logic [5:0] en,
                                               input logic [1:0] bk);
    logic [5:0] m;
    m = st & en;
    return {1'b0, bk, 1'b0, want_code(m), ~(|m)};
  endfunction

  function automatic logic [7:0] want_read(input logic [2:0] a);
    if (a == 3'd2) return want_irq_word(req_i, m_en, m_bank);
    if (m_bank != 2'd0) return 8'h00;
    if (a == 3'd0) return {2'b00, req_i};
    if (a == 3'd1) return {2'b00, m_en};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    check("R10 valid", {7'd0, rd_valid_o}, 8'd1);
    d = rd_data_o;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a == 3'd2) m_bank = d[6:5];
    else if (a == 3'd1 && m_bank == 2'd0) m_en = d[5:0];
  endtask

  // new requests become visible one edge later (R1, R6)
  task automatic set_req(input logic [5:0] v);
    @(negedge clk);
    req_i = v;
    @(negedge clk);
  endtask

  task automatic check_irq_pin(input string tag);
    logic [5:0] m;
    m = req_i & m_en;
    check(tag, {7'd0, irq_o}, {7'd0, |m});
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 irq", {7'd0, irq_o}, 8'd0);
    check("R9 valid", {7'd0, rd_valid_o}, 8'd0);
    do_read(3'd2, d); check("R9 irq reg", d, 8'h01);
    do_read(3'd1, d); check("R9 enable", d, 8'h00);
    do_read(3'd0, d); check("R9 status", d, 8'h00);

    // R1 status shows requests while nothing is enabled
    set_req(6'h2A);
    do_read(3'd0, d); check("R1 raw status", d, 8'h2A);
    check_irq_pin("R1 masked pin");
    do_read(3'd2, d); check("R4 idle flag", d, 8'h01);

    // R2 enable register
    do_write(3'd1, 8'hFF);
    do_read(3'd1, d); check("R2 enable read", d, 8'h3F);
    do_read(3'd2, d); check("R3 code", d, want_irq_word(req_i, m_en, m_bank));

    // R6 modem first, then timer replaces it one cycle later
    set_req(6'h20);
    do_read(3'd2, d); check("R3 modem", d, 8'h00);
    @(negedge clk); req_i = 6'h21;
    @(negedge clk);
    check("R5 pin", {7'd0, irq_o}, 8'd1);
    do_read(3'd2, d); check("R6 timer replaces", d, 8'h0A);

    // R7 write to interrupt register touches only bank bits
    do_write(3'd2, 8'hBF);
    do_read(3'd2, d); check("R7 bank only", d, want_irq_word(req_i, m_en, 2'd1));
    check("R8 bank1 reads", d & 8'h90, 8'h00);

    // R2 banks other than 0 hide status and enable
    do_read(3'd0, d); check("R2 status hidden", d, 8'h00);
    do_write(3'd1, 8'h00);
    do_read(3'd1, d); check("R2 enable hidden", d, 8'h00);
    do_write(3'd2, 8'h60);
    do_read(3'd2, d); check("R8 bank3", d, want_irq_word(req_i, m_en, 2'd3));
    do_write(3'd2, 8'h00);
    do_read(3'd1, d); check("R2 enable kept", d, 8'h3F);

    // R4 enabled but nothing pending
    set_req(6'h00);
    do_read(3'd2, d); check("R4 none pending", d, 8'h01);
    check("R5 pin low", {7'd0, irq_o}, 8'd0);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [5:0] v;
        v = 6'($urandom());
        set_req(v);
        check_irq_pin("R5 random pin");
      end else if (op < 5) begin
        do_write(3'd1, 8'($urandom()));
      end else if (op == 5) begin
        logic [7:0] w;
        w = 8'($urandom());
        if ($urandom_range(0, 2) != 0) w[6:5] = 2'd0;
        do_write(3'd2, w);
      end else begin
        logic [2:0] a;
        a = 3'($urandom_range(0, 3));
        do_read(a, d);
        if (a == 3'd2) check("R3 random code", d, want_read(a));
        else check("R2 random read", d, want_read(a));
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule